// File: doc/BRIEF.md
# Indirect NVRAM Byte Port with Lockable Windows

This block gives a processor access to a byte-wide non-volatile memory through a window of only four byte offsets. Two offsets load the low and high halves of a 16-bit address pointer. A third offset moves one data byte to or from the location that the pointer selects. Every data write returns the pointer to zero, so software must reload the address before each store. Reads leave the pointer where it is.

Two lock bits protect two fixed 16-byte windows near the bottom of the array. A protected window ignores stores and reads back all ones. A separate toggle input, driven by platform logic, flips one lock bit per pulse. Two addresses just above the top of the usable array are decoded specially. One is a read-only flags byte, which holds zero here because nothing in this block sets a flag. The other is a spare byte that reads as zero. Pointer values at or beyond the configured depth reach no storage.

Top module: `nvram_port`

## Requirements
- R1: A write at offset 0 replaces pointer bits [7:0], a write at offset 1 replaces bits [15:8], and a write at offset 2 changes neither the pointer nor the memory.
- R2: A write at offset 3 stores the byte at the pointer address, and the pointer then holds 0x0000.
- R3: A read at offset 3 returns the byte at the pointer address with `bus_rvalid` high on the second rising edge after the request edge, and it leaves the pointer unchanged.
- R4: A read at offset 0, 1 or 2 returns 0xFF.
- R5: While lock bit 0 is 1, addresses 0x20 to 0x2F ignore stores and read back 0xFF.
- R6: While lock bit 1 is 1, addresses 0x30 to 0x3F ignore stores and read back 0xFF.
- R7: A cycle with `lock_tgl` high inverts the lock bit whose index equals `lock_sel` (value 0 selects bit 0, value 1 selects bit 1).
- R8: Address DEPTH-16 is a read-only flags byte that reads 0x00, and address DEPTH-15 reads 0x00. Stores to either address are ignored.
- R9: For a pointer at or above DEPTH, stores do not reach storage (there is no aliasing onto low addresses) and reads return 0xFF.
- R10: Reset clears the pointer and both lock bits. It drives `bus_rvalid` and `bus_rdata` to 0 and leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Offset within the four-byte window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| bus_rvalid | output | 1 | Read byte valid |
| lock_tgl | input | 1 | Toggle request for one lock bit |
| lock_sel | input | 1 | Index of the lock bit to toggle |

## Verification
The bench builds the block with DEPTH set to 512 and keeps the default 16-bit pointer and two 16-byte windows at 0x20. With this depth, the whole array can be preloaded in a few thousand cycles. The flags and spare bytes then sit at 0x1F0 and 0x1F1, and the whole out-of-range region, including pointers that would alias onto low addresses if truncated, can be reached with short random pointers. Random mixes of pointer loads, stores, reads and lock toggles run against a shadow model, alongside directed cases for window edges, the spare offset and reset.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;

  typedef enum logic [2:0] {
    ACC_RAM,
    ACC_LOCKED,
    ACC_FLAGS,
    ACC_SPARE,
    ACC_OUTSIDE
  } acc_kind_e;

  localparam logic [1:0] OFF_PTR_LO = 2'd0;
  localparam logic [1:0] OFF_PTR_HI = 2'd1;
  localparam logic [1:0] OFF_SPARE  = 2'd2;
  localparam logic [1:0] OFF_DATA   = 2'd3;

  localparam logic [7:0] BYTE_ONES  = 8'hFF;
  localparam logic [7:0] FLAGS_IDLE = 8'h00;
  localparam logic [7:0] SPARE_VAL  = 8'h00;

endpackage

// File: rtl/nvram_ptr.sv
module nvram_ptr #(
  parameter int PTR_W = 16,
  localparam int LANES = PTR_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_ld,
  input  logic             clr,
  input  logic [7:0]       din,
  output logic [PTR_W-1:0] ptr_q
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ptr_q[b*8 +: 8] <= 8'h00;
      end else if (lane_ld[b]) begin
        ptr_q[b*8 +: 8] <= din;
      end
    end
  end

endmodule

// File: rtl/nvram_lock.sv
module nvram_lock #(
  parameter int NUM_LOCKS = 2,
  localparam int LIDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tgl,
  input  logic [LIDX_W-1:0]    sel,
  output logic [NUM_LOCKS-1:0] lock_q
);

  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q[n] <= 1'b0;
      end else if (tgl && (sel == LIDX_W'(n))) begin
        lock_q[n] <= ~lock_q[n];
      end
    end
  end

endmodule

// File: rtl/nvram_decode.sv
module nvram_decode
  import nvram_port_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int DEPTH     = 2048,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic [PTR_W-1:0]     ptr,
  input  logic [NUM_LOCKS-1:0] lock,
  output acc_kind_e            kind
);

  localparam logic [PTR_W-1:0] LIMIT     = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] FLAG_ADR  = PTR_W'(DEPTH - 16);
  localparam logic [PTR_W-1:0] SPARE_ADR = PTR_W'(DEPTH - 15);

  logic [NUM_LOCKS-1:0] win_hit;

  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_win
    localparam logic [PTR_W-1:0] LO = PTR_W'(LOCK_BASE + n * LOCK_SPAN);
    localparam logic [PTR_W-1:0] HI = PTR_W'(LOCK_BASE + (n + 1) * LOCK_SPAN - 1);
    assign win_hit[n] = lock[n] && (ptr >= LO) && (ptr <= HI);
  end

  always_comb begin
    if (ptr >= LIMIT) begin
      kind = ACC_OUTSIDE;
    end else if (ptr == FLAG_ADR) begin
      kind = ACC_FLAGS;
    end else if (ptr == SPARE_ADR) begin
      kind = ACC_SPARE;
    end else if (|win_hit) begin
      kind = ACC_LOCKED;
    end else begin
      kind = ACC_RAM;
    end
  end

endmodule

// File: rtl/nvram_ram.sv
module nvram_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/nvram_port.sv
module nvram_port
  import nvram_port_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int DEPTH     = 2048,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [1:0] bus_off,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  input  logic       lock_tgl,
  input  logic       lock_sel
);

  localparam int AW    = $clog2(DEPTH);
  localparam int LANES = PTR_W / 8;

  logic [PTR_W-1:0]     ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic [LANES-1:0]     lane_ld;
  acc_kind_e            kind;
  logic                 wr_cyc, rd_cyc, data_wr, data_rd;
  logic [7:0]           mem_q;
  logic                 rd_p1;
  acc_kind_e            kind_p1;

  assign wr_cyc  = bus_en && bus_we;
  assign rd_cyc  = bus_en && !bus_we;
  assign data_wr = wr_cyc && (bus_off == OFF_DATA);
  assign data_rd = rd_cyc && (bus_off == OFF_DATA);

  always_comb begin
    lane_ld = '0;
    if (wr_cyc && bus_off == OFF_PTR_LO) lane_ld[0] = 1'b1;
    if (wr_cyc && bus_off == OFF_PTR_HI) lane_ld[1] = 1'b1;
  end

  nvram_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .lane_ld (lane_ld),
    .clr     (data_wr),
    .din     (bus_wdata),
    .ptr_q   (ptr_q)
  );

  nvram_lock #(.NUM_LOCKS(NUM_LOCKS)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .tgl    (lock_tgl),
    .sel    (lock_sel),
    .lock_q (lock_q)
  );

  nvram_decode #(
    .PTR_W(PTR_W), .DEPTH(DEPTH), .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_dec (
    .ptr  (ptr_q),
    .lock (lock_q),
    .kind (kind)
  );

  nvram_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (data_wr && kind == ACC_RAM),
    .re    (data_rd && kind == ACC_RAM),
    .addr  (ptr_q[AW-1:0]),
    .wdata (bus_wdata),
    .rdata (mem_q)
  );

  // stage 1: remember what the returned byte must come from
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1   <= 1'b0;
      kind_p1 <= ACC_OUTSIDE;
    end else begin
      rd_p1   <= rd_cyc;
      kind_p1 <= (bus_off == OFF_DATA) ? kind : ACC_OUTSIDE;
    end
  end

  // stage 2: registered output mux
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= rd_p1;
      if (rd_p1) begin
        case (kind_p1)
          ACC_RAM:   bus_rdata <= mem_q;
          ACC_FLAGS: bus_rdata <= FLAGS_IDLE;
          ACC_SPARE: bus_rdata <= SPARE_VAL;
          default:   bus_rdata <= BYTE_ONES;
        endcase
      end
    end
  end

endmodule

// File: rtl/nvram_port_chk.sv
module nvram_port_chk #(
  parameter int PTR_W     = 16,
  parameter int DEPTH     = 2048,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [1:0]           bus_off,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic                 bus_rvalid,
  input logic                 lock_tgl,
  input logic                 lock_sel,
  input logic [PTR_W-1:0]     ptr_q,
  input logic [NUM_LOCKS-1:0] lock_q
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] W0_LO = PTR_W'(LOCK_BASE);
  localparam logic [PTR_W-1:0] W0_HI = PTR_W'(LOCK_BASE + LOCK_SPAN - 1);
  localparam logic [PTR_W-1:0] W1_LO = PTR_W'(LOCK_BASE + LOCK_SPAN);
  localparam logic [PTR_W-1:0] W1_HI = PTR_W'(LOCK_BASE + 2 * LOCK_SPAN - 1);

  logic rd_data;
  assign rd_data = bus_en && !bus_we && bus_off == 2'd3;

  p_lo_load_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_off == 2'd0) |=>
      (ptr_q[7:0] == $past(bus_wdata)) && (ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8])));

  p_spare_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_off == 2'd2) |=> $stable(ptr_q));

  p_ptr_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_off == 2'd3) |=> (ptr_q == '0));

  p_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we) |=> ##1 bus_rvalid);

  p_rd_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !lock_tgl) |=> $stable(ptr_q));

  p_other_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_off != 2'd3) |=> ##1 (bus_rdata == 8'hFF));

  p_win0_ff_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && lock_q[0] && ptr_q >= W0_LO && ptr_q <= W0_HI) |=> ##1 (bus_rdata == 8'hFF));

  p_win1_ff_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_data && lock_q[1] && ptr_q >= W1_LO && ptr_q <= W1_HI) |=> ##1 (bus_rdata == 8'hFF));

  p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    lock_tgl |=> ($countones(lock_q ^ $past(lock_q)) == 1) && (lock_q[$past(lock_sel)] != $past(lock_q[lock_sel])));

  p_outside_ff_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_data && ptr_q >= LIMIT) |=> ##1 (bus_rdata == 8'hFF));

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_q == '0) && (lock_q == '0) && !bus_rvalid);

endmodule

bind nvram_port nvram_port_chk #(
  .PTR_W(PTR_W), .DEPTH(DEPTH), .NUM_LOCKS(NUM_LOCKS),
  .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .lock_tgl(lock_tgl), .lock_sel(lock_sel), .ptr_q(ptr_q), .lock_q(lock_q)
);

// File: tb/nvram_port_tb.sv
module nvram_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_off = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       lock_tgl = 1'b0, lock_sel = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int m_ptr = 0;
  bit [1:0] m_lock = 2'b00;
  logic [7:0] shadow [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvram_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lock_tgl(lock_tgl), .lock_sel(lock_sel)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic bit locked(int a);
    return (m_lock[0] && a >= 32 && a <= 47) || (m_lock[1] && a >= 48 && a <= 63);
  endfunction

  function automatic int exp_read(int a);
    if (a >= DEPTH) return 8'hFF;
    if (a == DEPTH - 16 || a == DEPTH - 15) return 8'h00;
    if (locked(a)) return 8'hFF;
    return shadow[a];
  endfunction

  task automatic bus_wr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (off == 2'd0) m_ptr = (m_ptr & 16'hFF00) | d;
    if (off == 2'd1) m_ptr = (m_ptr & 16'h00FF) | (int'(d) << 8);
    if (off == 2'd3) begin
      if (m_ptr < DEPTH && m_ptr != DEPTH - 16 && m_ptr != DEPTH - 15 && !locked(m_ptr))
        shadow[m_ptr] = d;
      m_ptr = 0;
    end
  endtask

  task automatic bus_rd(input logic [1:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_off = off;
    @(negedge clk);
    bus_en = 1'b0;
    @(posedge clk);
    #1;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic set_ptr(input int a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, a[15:8]);
  endtask

  task automatic toggle(input logic idx);
    @(negedge clk);
    lock_tgl = 1'b1; lock_sel = idx;
    @(negedge clk);
    lock_tgl = 1'b0;
    m_lock[idx] = ~m_lock[idx];
  endtask

  task automatic rd_at(input int a, input string req);
    logic [7:0] d; logic v;
    set_ptr(a);
    bus_rd(2'd3, d, v);
    check({req, " rvalid"}, v, 1);
    check({req, " data"}, d, exp_read(a));
  endtask

  initial begin
    logic [7:0] d; logic v;
    void'($urandom(32'h1F0C_55A3));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset rvalid", bus_rvalid, 0);
    check("R10 reset rdata", bus_rdata, 0);
    @(negedge clk); rst = 1'b0;

    for (int a = 0; a < DEPTH; a++) begin
      set_ptr(a);
      bus_wr(2'd3, 8'((a * 7 + 3) & 8'hFF));
    end
    rd_at(5, "R3 fill readback");
    rd_at(DEPTH - 17, "R3 top readback");

    // R1: high byte alone, then spare offset must not move pointer
    set_ptr(16'h0134); bus_wr(2'd2, 8'h77); bus_wr(2'd3, 8'hC1);
    rd_at(16'h0134, "R1 offset 2 ignored");
    // R3: read does not move pointer
    set_ptr(9); bus_rd(2'd3, d, v); bus_wr(2'd3, 8'h9E);
    rd_at(9, "R3 pointer kept by read");
    // R2: pointer cleared after data write
    set_ptr(17); bus_wr(2'd3, 8'h11); bus_wr(2'd3, 8'h4D);
    rd_at(0, "R2 pointer cleared");
    rd_at(17, "R2 stored byte");
    // R4
    for (int o = 0; o < 3; o++) begin
      bus_rd(2'(o), d, v);
      check("R4 other offset", d, 8'hFF);
    end
    // R8
    set_ptr(DEPTH - 16); bus_wr(2'd3, 8'h5A);
    rd_at(DEPTH - 16, "R8 flags");
    set_ptr(DEPTH - 15); bus_wr(2'd3, 8'hA5);
    rd_at(DEPTH - 15, "R8 spare");
    // R9: no aliasing
    set_ptr(DEPTH + 5); bus_wr(2'd3, 8'h3C);
    rd_at(5, "R9 no alias");
    rd_at(DEPTH + 5, "R9 outside read");
    rd_at(16'hFFFF, "R9 top pointer");
    // R5 / R6 / R7 window edges
    toggle(1'b0);
    set_ptr(32); bus_wr(2'd3, 8'hEE);
    rd_at(32, "R5 lo edge");
    rd_at(47, "R5 hi edge");
    rd_at(48, "R6 unlocked neighbour");
    rd_at(31, "R5 below window");
    toggle(1'b1);
    set_ptr(63); bus_wr(2'd3, 8'hDD);
    rd_at(63, "R6 hi edge");
    rd_at(64, "R6 above window");
    toggle(1'b0);
    rd_at(32, "R7 unlock restores");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int a, sel;
      sel = $urandom % 4;
      case (sel)
        0: a = $urandom % DEPTH;
        1: a = 28 + $urandom % 40;
        2: a = DEPTH - 18 + $urandom % 6;
        default: a = DEPTH + $urandom % 64;
      endcase
      case ($urandom % 5)
        0, 1: begin set_ptr(a); bus_wr(2'd3, 8'($urandom)); end
        2: rd_at(a, "R3 random read");
        3: toggle(1'($urandom));
        default: rd_at(a % DEPTH, "R9 random alias read");
      endcase
    end
    // R10: reset clears pointer and locks, keeps array
    if (!m_lock[0]) toggle(1'b0);
    set_ptr(16'h0155);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_ptr = 0; m_lock = 2'b00;
    bus_wr(2'd3, 8'h6B);
    rd_at(0, "R10 pointer cleared");
    rd_at(40, "R10 locks cleared");
    rd_at(100, "R10 array kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule